// File: doc/BRIEF.md
# Trit Recode and Word Serializer

This block is the electronic write and read datapath between a wide ternary processing array and a byte-addressed memory with a fixed word width. On the write side, each trit of a result arrives as a latched pair of detector levels. The block converts every pair into the standard two-bit ternary storage code and captures the whole converted result in a holding register. It then streams the result out as consecutive memory words, one per beat, under a valid/ready handshake. Each word carries its index so that the surrounding address logic can place it at the right byte offset. A result of n trits needs at least ceil(2n/8) byte cells.

On the read side, the block takes memory words tagged with their index and assembles them into a full result. Once the final word has arrived, it publishes two control bits per trit for the light modulators. Stored codes are already in standard form, so the read side does no recoding. The first control bit of a trit is the NOR of its two code bits, and the second is its low code bit.

Top module: `trit_word_path`

## Requirements
- R1: After a synchronous active-low reset, det_ready is 1, and wr_valid, out_valid and code_err are all 0.
- R2: Trit t occupies det_pairs[2t+1:2t]. A detector pair of 11 (vertical) is stored as 01 (trit 1), 10 (horizontal) is stored as 10 (trit u), and 00 (dark) is stored as 00 (trit 0).
- R3: A detector pair of 01 is stored as the reserved code 11. code_err is 1 while a result that contains such a pair is being sent, and 0 otherwise.
- R4: Words leave least-significant first. The word with wr_idx = k carries bits [W*k+W-1:W*k] of the converted result, and wr_last is 1 only on the final index.
- R5: When wr_ready is held high, the words of one result go out on consecutive cycles, and word 0 is valid in the cycle after the result is accepted.
- R6: While wr_valid is 1 and wr_ready is 0, wr_data, wr_idx and wr_last hold steady and no word is skipped.
- R7: det_ready is 0 from the accept cycle until the final word is taken. det_pairs and det_valid have no effect during that time. det_ready is 1 again in the cycle after the final word is taken.
- R8: A word presented with rd_valid is stored at slot rd_idx. out_valid pulses for exactly one cycle, one cycle after the word with the final index is accepted.
- R9: For every trit t of the assembled result, mod_a[t] is the NOR of its two code bits and mod_b[t] is its low code bit, with no recoding applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_valid | input | 1 | A detector result is offered |
| det_ready | output | 1 | The serializer is idle and can accept a result |
| det_pairs | input | 2*TRITS | Latched detector level pairs, two bits per trit |
| code_err | output | 1 | The result being sent held an illegal detector pair |
| wr_valid | output | 1 | A memory word is offered |
| wr_ready | input | 1 | The memory side takes the word |
| wr_data | output | WORD_W | Memory word |
| wr_idx | output | IDX_W | Index of the word within the result |
| wr_last | output | 1 | Final word of the result |
| rd_valid | input | 1 | A read word is presented |
| rd_idx | input | IDX_W | Slot of the read word |
| rd_data | input | WORD_W | Read word |
| out_valid | output | 1 | One-cycle pulse when an assembled result is published |
| mod_a | output | TRITS | First modulator control, NOR of each trit's code bits |
| mod_b | output | TRITS | Second modulator control, low code bit of each trit |

## Verification
The assertions assume that rd_idx always names an existing slot whenever rd_valid is high. They also assume that the memory side honours the handshake, so that a word is only counted as taken on a cycle where wr_valid and wr_ready are both high. The bench uses a small configuration of twelve trits in 8-bit words. It loops every write word straight back into the read port with its own index, so rd_idx never leaves the valid range and the read-side checks follow from the write-side ones. Stalls are placed only on beats where a word is already being offered, and det_pairs is deliberately changed while the serializer is busy, to show that this input is ignored during a transfer.

// File: rtl/trit_wpkg.sv
// Package: shared code constants and the detector-to-storage pair mapping.
// Assumes two bits per trit on both the detector and the storage side.
package trit_wpkg;

    typedef logic [1:0] pair_t;

    // Storage code values
    localparam pair_t CODE_ZERO = 2'b00;
    localparam pair_t CODE_ONE  = 2'b01;
    localparam pair_t CODE_U    = 2'b10;
    localparam pair_t CODE_RSV  = 2'b11;

    // Detector latch pair values
    localparam pair_t DET_DARK  = 2'b00;
    localparam pair_t DET_HORIZ = 2'b10;
    localparam pair_t DET_VERT  = 2'b11;

    // Maps one detector pair onto its storage code; the illegal pair goes to the reserved code
    function automatic pair_t map_pair(input pair_t d);
        pair_t r;
        case (d)
            DET_VERT:  r = CODE_ONE;
            DET_HORIZ: r = CODE_U;
            DET_DARK:  r = CODE_ZERO;
            default:   r = CODE_RSV;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trit_recode.sv
// Module: trit_recode
// Converts every detector pair of a result into its storage code and flags any
// pair that no detector state can produce. Purely combinational.
// Assumes trit t sits at bits [2t+1:2t].
module trit_recode
    import trit_wpkg::*;
#(
    parameter int TRITS = 192
) (
    input  logic [2*TRITS-1:0] det_bits,
    output logic [2*TRITS-1:0] code_bits,
    output logic               bad_any
);

    logic [TRITS-1:0] bad;

    for (genvar t = 0; t < TRITS; t++) begin : g_trit
        // Per-trit remap and illegal-pair detect
        assign code_bits[2*t +: 2] = map_pair(det_bits[2*t +: 2]);
        assign bad[t]              = (det_bits[2*t +: 2] == 2'b01);
    end

    assign bad_any = |bad;

endmodule

// File: rtl/word_serializer.sv
// Module: word_serializer
// Captures a full converted result into a holding register, then emits it as
// WORD_W-bit words, least-significant first, under valid/ready.
// Assumes the downstream side only takes a word when valid and ready are both high.
module word_serializer #(
    parameter int BITS   = 384,
    parameter int WORD_W = 64,
    localparam int NWORDS = (BITS + WORD_W - 1) / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int PAD    = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    output logic              load_ready,
    input  logic [BITS-1:0]   load_bits,
    input  logic              load_err,
    output logic              err_held,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_last
);

    logic [PAD-1:0]   hold;
    logic             busy;
    logic [IDX_W-1:0] idx;

    // Capture a result when idle, then walk the word index on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            busy     <= 1'b0;
            idx      <= '0;
            err_held <= 1'b0;
        end else if (!busy) begin
            if (load_valid) begin
                hold            <= '0;
                hold[BITS-1:0]  <= load_bits;
                err_held        <= load_err;
                busy            <= 1'b1;
                idx             <= '0;
            end
        end else if (out_ready) begin
            if (idx == IDX_W'(NWORDS - 1)) begin
                busy     <= 1'b0;
                err_held <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Word select and handshake outputs
    assign load_ready = !busy;
    assign out_valid  = busy;
    assign out_idx    = idx;
    assign out_last   = (idx == IDX_W'(NWORDS - 1));
    assign out_word   = hold[idx*WORD_W +: WORD_W];

    a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_idx)));

    a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    a_r7_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (load_ready && !out_valid));

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_idx} < (IDX_W+1)'(NWORDS)));

endmodule

// File: rtl/word_gather.sv
// Module: word_gather
// Assembles indexed read words into a full result and, when the final slot is
// written, publishes per-trit modulator control bits. Stored codes are used as is.
// Assumes in_idx names an existing slot whenever in_valid is high.
module word_gather #(
    parameter int TRITS  = 192,
    parameter int WORD_W = 64,
    localparam int BITS   = 2 * TRITS,
    localparam int NWORDS = (BITS + WORD_W - 1) / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int PAD    = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_pulse,
    output logic [TRITS-1:0]  mod_a,
    output logic [TRITS-1:0]  mod_b
);

    logic [PAD-1:0]  asm_q;
    logic [PAD-1:0]  merged;
    logic [BITS-1:0] frozen;
    logic            last_hit;

    // Overlay the incoming word on the partial assembly
    always_comb begin
        merged = asm_q;
        merged[in_idx*WORD_W +: WORD_W] = in_word;
    end

    assign last_hit = in_valid && (in_idx == IDX_W'(NWORDS - 1));

    // Store words by slot and freeze the result when the final slot arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q     <= '0;
            frozen    <= '0;
            out_pulse <= 1'b0;
        end else begin
            if (in_valid) asm_q <= merged;
            if (last_hit) frozen <= merged[BITS-1:0];
            out_pulse <= last_hit;
        end
    end

    for (genvar t = 0; t < TRITS; t++) begin : g_mod
        // Per-trit modulator drive from the stored code pair
        assign mod_a[t] = ~(frozen[2*t+1] | frozen[2*t]);
        assign mod_b[t] = frozen[2*t];
    end

    a_r8_pulse_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_idx == IDX_W'(NWORDS - 1)) |=> out_pulse);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> $past(in_valid));

endmodule

// File: rtl/trit_word_path.sv
// Module: trit_word_path (top)
// Write side: detector pairs are recoded and serialized into indexed memory words.
// Read side: indexed memory words are gathered and turned into modulator bits.
// Assumes one result in flight on the write side at a time.
module trit_word_path #(
    parameter int TRITS  = 192,
    parameter int WORD_W = 64,
    localparam int BITS   = 2 * TRITS,
    localparam int NWORDS = (BITS + WORD_W - 1) / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_valid,
    output logic              det_ready,
    input  logic [BITS-1:0]   det_pairs,
    output logic              code_err,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_data,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_last,
    input  logic              rd_valid,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_data,
    output logic              out_valid,
    output logic [TRITS-1:0]  mod_a,
    output logic [TRITS-1:0]  mod_b
);

    logic [BITS-1:0] code_bits;
    logic            bad_any;

    trit_recode #(.TRITS(TRITS)) u_recode (
        .det_bits  (det_pairs),
        .code_bits (code_bits),
        .bad_any   (bad_any)
    );

    word_serializer #(.BITS(BITS), .WORD_W(WORD_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (det_valid),
        .load_ready (det_ready),
        .load_bits  (code_bits),
        .load_err   (bad_any),
        .err_held   (code_err),
        .out_valid  (wr_valid),
        .out_ready  (wr_ready),
        .out_word   (wr_data),
        .out_idx    (wr_idx),
        .out_last   (wr_last)
    );

    word_gather #(.TRITS(TRITS), .WORD_W(WORD_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_valid),
        .in_idx    (rd_idx),
        .in_word   (rd_data),
        .out_pulse (out_valid),
        .mod_a     (mod_a),
        .mod_b     (mod_b)
    );

endmodule

// File: tb/trit_word_path_tb.sv
module trit_word_path_tb;

    localparam int TRITS  = 12;
    localparam int WORD_W = 8;
    localparam int BITS   = 2 * TRITS;
    localparam int NWORDS = (BITS + WORD_W - 1) / WORD_W;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              det_valid = 1'b0;
    logic              det_ready;
    logic [BITS-1:0]   det_pairs = '0;
    logic              code_err;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [WORD_W-1:0] wr_data;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_last;
    logic              rd_valid = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [WORD_W-1:0] rd_data = '0;
    logic              out_valid;
    logic [TRITS-1:0]  mod_a;
    logic [TRITS-1:0]  mod_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trit_word_path #(.TRITS(TRITS), .WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .det_valid(det_valid), .det_ready(det_ready), .det_pairs(det_pairs),
        .code_err(code_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_idx(wr_idx), .wr_last(wr_last),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected storage code for a whole result, by arithmetic on each pair
    function automatic logic [BITS-1:0] exp_code(input logic [BITS-1:0] d);
        logic [BITS-1:0] r;
        for (int t = 0; t < TRITS; t++) begin
            int v;
            v = int'(d[2*t +: 2]);
            r[2*t +: 2] = 2'((v == 3) ? 1 : (v == 1) ? 3 : v);
        end
        return r;
    endfunction

    function automatic bit exp_err(input logic [BITS-1:0] d);
        bit e = 1'b0;
        for (int t = 0; t < TRITS; t++) if (d[2*t +: 2] == 2'b01) e = 1'b1;
        return e;
    endfunction

    task automatic run(input logic [BITS-1:0] pairs, input bit stall);
        logic [BITS-1:0]   code;
        logic [TRITS-1:0]  ea;
        logic [TRITS-1:0]  eb;
        logic [WORD_W-1:0] held;
        code = exp_code(pairs);
        for (int t = 0; t < TRITS; t++) begin
            ea[t] = ~(code[2*t+1] | code[2*t]);
            eb[t] = code[2*t];
        end
        @(negedge clk);
        det_pairs = pairs; det_valid = 1'b1;
        chk(det_ready == 1'b1, "R7 idle ready", 64'(det_ready), 64'd1);
        @(negedge clk);
        det_pairs = ~pairs;  // must be ignored while busy (R7)
        chk(code_err == exp_err(pairs), "R3 error flag", 64'(code_err), 64'(exp_err(pairs)));
        chk(det_ready == 1'b0, "R7 busy", 64'(det_ready), 64'd0);
        for (int k = 0; k < NWORDS; k++) begin
            if (stall && (k % 2 == 0)) begin
                wr_ready = 1'b0; rd_valid = 1'b0;
                held = wr_data;
                @(negedge clk);
                chk(wr_valid && wr_data == held && int'(wr_idx) == k, "R6 stall hold",
                    64'(wr_data), 64'(held));
            end
            wr_ready = 1'b1;
            chk(wr_valid == 1'b1, "R5 back-to-back valid", 64'(wr_valid), 64'd1);
            chk(int'(wr_idx) == k, "R4 index", 64'(wr_idx), 64'(k));
            chk(wr_last == (k == NWORDS - 1), "R4 last flag", 64'(wr_last), 64'(k == NWORDS - 1));
            chk(wr_data == code[k*WORD_W +: WORD_W], "R2 word content",
                64'(wr_data), 64'(code[k*WORD_W +: WORD_W]));
            if (k < NWORDS - 1)
                chk(out_valid == 1'b0, "R8 no early publish", 64'(out_valid), 64'd0);
            rd_valid = 1'b1; rd_idx = wr_idx; rd_data = wr_data;
            @(negedge clk);
        end
        det_valid = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0;
        chk(wr_valid == 1'b0, "R7 done", 64'(wr_valid), 64'd0);
        chk(det_ready == 1'b1, "R7 ready again", 64'(det_ready), 64'd1);
        chk(out_valid == 1'b1, "R8 publish pulse", 64'(out_valid), 64'd1);
        chk(mod_a == ea, "R9 mod_a", 64'(mod_a), 64'(ea));
        chk(mod_b == eb, "R9 mod_b", 64'(mod_b), 64'(eb));
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 pulse width", 64'(out_valid), 64'd0);
        chk(code_err == 1'b0, "R3 flag clears", 64'(code_err), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(det_ready == 1'b1, "R1 det_ready", 64'(det_ready), 64'd1);
        chk(wr_valid == 1'b0, "R1 wr_valid", 64'(wr_valid), 64'd0);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(code_err == 1'b0, "R1 code_err", 64'(code_err), 64'd0);
        // Each code at each trit position over three backgrounds (R2, R3)
        for (int b = 0; b < 3; b++) begin
            for (int t = 0; t < TRITS; t++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [BITS-1:0] p;
                    for (int u = 0; u < TRITS; u++) p[2*u +: 2] = 2'((b == 0) ? 0 : (b == 1) ? 3 : 2);
                    p[2*t +: 2] = 2'(c);
                    run(p, (c % 2) == 1);
                end
            end
        end
        // Mixed patterns, legal only and with illegal pairs
        for (int i = 0; i < 60; i++) begin
            logic [BITS-1:0] p;
            p = BITS'($urandom);
            if (i % 2 == 0)
                for (int u = 0; u < TRITS; u++) if (p[2*u +: 2] == 2'b01) p[2*u +: 2] = 2'b11;
            run(p, (i % 3) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule